// File: doc/BRIEF.md
# Speculative Region Line Tracking Buffer

This block follows the cache lines one core protects while it runs a speculative region, and decides when that region has to be thrown away. The core issues local requests on a single request port: begin a region, protected load, protected store, watch a line for remote stores, watch a line for any remote access, stop watching a line, abort on purpose, commit, and plain (nonspeculative) loads and stores. Remote read, write, prefetch and exclusive-prefetch requests seen on the coherence side arrive on a snoop port, and each is resolved against a small fully-associative table that marks every protected line as shared or owned.

The remote requester always wins. A conflicting snoop, a protected request that needs a new entry in a full table, or an explicit abort ends the region at once, drops every buffered speculative store, and reports a 2-bit cause. The block also reports the restart point captured when the region began, and the status the begin request returns on the path back after an abort. A commit releases every entry and presents all buffered store data for one cycle on a write-back port so that the surrounding memory system can make it visible together.

Top module: `spec_line_tracker`

## Requirements
- R1: Conflicts are matched on the line address only (address bits above the low OFF_W offset bits); two addresses in the same line conflict whatever their offsets.
- R2: A protected request for a line not in the table while all ENTRIES entries are valid ends the region with cause capacity (2'b10); a protected request to a line already held while the table is full is accepted.
- R3: Snoop kinds are 2'b00 read, 2'b01 prefetch, 2'b10 write, 2'b11 exclusive prefetch. A read or prefetch of a line held shared does not abort; the same snoop of a line held owned aborts with cause contention (2'b01).
- R4: A write or exclusive-prefetch snoop of any held line, shared or owned, aborts with cause contention; the snoop is never stalled or refused, and a contention abort takes priority over a local request in the same cycle.
- R5: Request codes are 0 begin, 1 protected load, 2 protected store, 3 watch for stores, 4 watch for all accesses, 5 release, 6 explicit abort, 7 commit, 8 plain load, 9 plain store. Codes 1 and 3 mark the line shared, codes 2 and 4 mark it owned, and a shared line is upgraded to owned by a later code 2 or 4; a line never moves back from owned to shared.
- R6: A release removes a line without buffered store data from the table, after which no snoop to it aborts; a line holding buffered store data stays protected.
- R7: An explicit abort ends the region with cause explicit (2'b11); any abort discards all buffered store data, so no write-back appears for it.
- R8: A begin request while no region is active activates the region, returns status 0 and captures req_data_i as the restart point; after an abort the status output holds the nonzero cause. A begin request while a region is active is ignored.
- R9: A protected line is monitored from the clock edge that accepts its request; a snoop presented in the same cycle as that request is resolved against the table as it stood before it.
- R10: A plain store during a region to a line held in the table raises the illegal-store flag for one cycle without ending the region; a plain store to another line, or a plain load, does not.
- R11: A commit during a region empties the table, ends the region and, in the following cycle only, presents every buffered line with its latest store data on the write-back port; a commit, or any request other than begin, while no region is active is ignored.
- R12: The cause output is 2'b00 after reset and after a begin, becomes the abort cause in the cycle after the abort, and holds until the next accepted begin; snoops while no region is active change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Local request present |
| req_op_i | input | 4 | Local request code (see R5) |
| req_addr_i | input | ADDR_W | Byte address of the local request |
| req_data_i | input | DATA_W | Store data, or restart point on begin |
| snoop_valid_i | input | 1 | Remote request present |
| snoop_kind_i | input | 2 | Remote request kind (see R3) |
| snoop_addr_i | input | ADDR_W | Byte address of the remote request |
| active_o | output | 1 | A speculative region is running |
| abort_o | output | 1 | One-cycle pulse: the region was aborted |
| abort_cause_o | output | 2 | 00 none, 01 contention, 10 capacity, 11 explicit |
| start_status_o | output | 2 | Status the begin request returns: 0 on entry, cause after abort |
| restart_pc_o | output | DATA_W | Restart point captured at begin |
| illegal_o | output | 1 | One-cycle pulse: plain store to a protected line |
| wb_mask_o | output | ENTRIES | Write-back slots valid, one cycle after commit |
| wb_line_o | output | ENTRIES*(ADDR_W-OFF_W) | Line addresses of the write-back slots |
| wb_data_o | output | ENTRIES*DATA_W | Store data of the write-back slots |

## Verification
The hardest situation to reach is a full table in which one more protected request arrives for a new line, since every entry must first be filled through accepted requests while no snoop disturbs the region; the stimulus fills all eight entries with distinct lines, repeats a request to a held line to show that hits still pass, and only then asks for a ninth line. Equally delicate is the single cycle in which a snoop and the request that protects the same line arrive together, which the stimulus drives on one edge and then follows with a second snoop on the next edge. A behavioural model built from queues predicts every output on every clock, and the write-back port is compared as an unordered set because slot placement is free.

// File: rtl/slt_pkg.sv
`timescale 1ns/1ps
package slt_pkg;

  typedef enum logic [3:0] {
    OP_BEGIN    = 4'd0,
    OP_PLOAD    = 4'd1,
    OP_PSTORE   = 4'd2,
    OP_WATCH_S  = 4'd3,
    OP_WATCH_X  = 4'd4,
    OP_RELEASE  = 4'd5,
    OP_ABORT    = 4'd6,
    OP_COMMIT   = 4'd7,
    OP_NS_LOAD  = 4'd8,
    OP_NS_STORE = 4'd9
  } slt_op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_CONT = 2'b01,
    CAUSE_CAP  = 2'b10,
    CAUSE_EXPL = 2'b11
  } slt_cause_e;

  // snoop kind bit 1 set: write or exclusive prefetch
  localparam int unsigned SNP_EXCL_BIT = 1;

endpackage

// File: rtl/slt_pick.sv
`timescale 1ns/1ps
module slt_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] oh_o,
  output logic         any_o
);

  always_comb begin
    logic found;
    found = 1'b0;
    oh_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (free_i[i] && !found) begin
        oh_o[i] = 1'b1;
        found   = 1'b1;
      end
    end
    any_o = found;
  end

endmodule

// File: rtl/slt_entry.sv
`timescale 1ns/1ps
module slt_entry #(
  parameter int unsigned LINE_W = 26,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic              wr_own_i,
  input  logic              wr_data_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rel_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [LINE_W-1:0] snp_line_i,
  input  logic              snp_excl_i,
  output logic              valid_o,
  output logic              req_hit_o,
  output logic              snp_cfl_o,
  output logic              has_data_o,
  output logic [LINE_W-1:0] line_o,
  output logic [DATA_W-1:0] data_o
);

  logic              valid_q, own_q, has_q;
  logic [LINE_W-1:0] line_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      own_q   <= 1'b0;
      has_q   <= 1'b0;
      line_q  <= '0;
      data_q  <= '0;
    end else if (clr_i) begin
      valid_q <= 1'b0;
      own_q   <= 1'b0;
      has_q   <= 1'b0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      line_q  <= req_line_i;
      own_q   <= (valid_q & own_q) | wr_own_i;
      has_q   <= (valid_q & has_q) | wr_data_en_i;
      if (wr_data_en_i) data_q <= wr_data_i;
    end else if (rel_i && !has_q) begin
      valid_q <= 1'b0;
      own_q   <= 1'b0;
    end
  end

  assign valid_o    = valid_q;
  assign req_hit_o  = valid_q && (line_q == req_line_i);
  // requester wins: exclusive snoops hit any state, shared snoops only owned lines
  assign snp_cfl_o  = valid_q && (line_q == snp_line_i) && (snp_excl_i || own_q);
  assign has_data_o = has_q;
  assign line_o     = line_q;
  assign data_o     = data_q;

  // buffered data implies owned state
  assert_data_owned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    has_q |-> (valid_q && own_q));

  // a line with buffered data survives a release
  assert_release_keeps_data_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_i && has_q && !clr_i && !wr_i) |=> valid_q);

endmodule

// File: rtl/spec_line_tracker.sv
`timescale 1ns/1ps
module spec_line_tracker
  import slt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned OFF_W   = 6,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENTRIES = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              req_valid_i,
  input  logic [3:0]                        req_op_i,
  input  logic [ADDR_W-1:0]                 req_addr_i,
  input  logic [DATA_W-1:0]                 req_data_i,
  input  logic                              snoop_valid_i,
  input  logic [1:0]                        snoop_kind_i,
  input  logic [ADDR_W-1:0]                 snoop_addr_i,
  output logic                              active_o,
  output logic                              abort_o,
  output logic [1:0]                        abort_cause_o,
  output logic [1:0]                        start_status_o,
  output logic [DATA_W-1:0]                 restart_pc_o,
  output logic                              illegal_o,
  output logic [ENTRIES-1:0]                wb_mask_o,
  output logic [ENTRIES*(ADDR_W-OFF_W)-1:0] wb_line_o,
  output logic [ENTRIES*DATA_W-1:0]         wb_data_o
);

  localparam int unsigned LINE_W = ADDR_W - OFF_W;

  slt_op_e           op;
  logic [LINE_W-1:0] req_line, snp_line;
  logic              snp_excl;

  assign op       = slt_op_e'(req_op_i);
  assign req_line = req_addr_i[ADDR_W-1:OFF_W];
  assign snp_line = snoop_addr_i[ADDR_W-1:OFF_W];
  assign snp_excl = snoop_kind_i[SNP_EXCL_BIT];

  logic [ENTRIES-1:0] valid_v, hit_v, cfl_v, has_v, wr_v, rel_v, free_oh;
  logic [LINE_W-1:0]  line_a [ENTRIES];
  logic [DATA_W-1:0]  data_a [ENTRIES];
  logic               free_any;

  logic       active_q, abort_q, illegal_q;
  slt_cause_e cause_q, cause_d;
  logic [1:0] status_q;
  logic [DATA_W-1:0] pc_q;
  logic [ENTRIES-1:0] wb_mask_q;
  logic [LINE_W-1:0]  wb_line_q [ENTRIES];
  logic [DATA_W-1:0]  wb_data_q [ENTRIES];

  logic act_req, conflict, is_prot, is_own, cap, expl, abort_now;
  logic ok, commit_now, begin_now, clr, illegal_d, any_hit;

  slt_pick #(.N(ENTRIES)) u_pick (
    .free_i (~valid_v),
    .oh_o   (free_oh),
    .any_o  (free_any)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    slt_entry #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_ent (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .clr_i        (clr),
      .wr_i         (wr_v[g]),
      .wr_own_i     (is_own),
      .wr_data_en_i (op == OP_PSTORE),
      .wr_data_i    (req_data_i),
      .rel_i        (rel_v[g]),
      .req_line_i   (req_line),
      .snp_line_i   (snp_line),
      .snp_excl_i   (snp_excl),
      .valid_o      (valid_v[g]),
      .req_hit_o    (hit_v[g]),
      .snp_cfl_o    (cfl_v[g]),
      .has_data_o   (has_v[g]),
      .line_o       (line_a[g]),
      .data_o       (data_a[g])
    );
    assign wb_line_o[g*LINE_W +: LINE_W] = wb_line_q[g];
    assign wb_data_o[g*DATA_W +: DATA_W] = wb_data_q[g];
  end

  always_comb begin
    act_req    = active_q && req_valid_i;
    conflict   = active_q && snoop_valid_i && (|cfl_v);
    is_prot    = op inside {OP_PLOAD, OP_PSTORE, OP_WATCH_S, OP_WATCH_X};
    is_own     = op inside {OP_PSTORE, OP_WATCH_X};
    any_hit    = |hit_v;
    cap        = act_req && is_prot && !any_hit && !free_any;
    expl       = act_req && (op == OP_ABORT);
    abort_now  = conflict || cap || expl;
    if (conflict)  cause_d = CAUSE_CONT;
    else if (cap)  cause_d = CAUSE_CAP;
    else if (expl) cause_d = CAUSE_EXPL;
    else           cause_d = CAUSE_NONE;
    ok         = act_req && !abort_now;
    commit_now = ok && (op == OP_COMMIT);
    begin_now  = !active_q && req_valid_i && (op == OP_BEGIN);
    clr        = abort_now || commit_now || begin_now;
    wr_v       = (ok && is_prot) ? (any_hit ? hit_v : free_oh) : '0;
    rel_v      = (ok && (op == OP_RELEASE)) ? hit_v : '0;
    illegal_d  = ok && (op == OP_NS_STORE) && any_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      abort_q   <= 1'b0;
      illegal_q <= 1'b0;
      cause_q   <= CAUSE_NONE;
      status_q  <= 2'b00;
      pc_q      <= '0;
      wb_mask_q <= '0;
    end else begin
      abort_q   <= abort_now;
      illegal_q <= illegal_d;
      wb_mask_q <= commit_now ? (valid_v & has_v) : '0;
      if (begin_now) begin
        active_q <= 1'b1;
        cause_q  <= CAUSE_NONE;
        status_q <= 2'b00;
        pc_q     <= req_data_i;
      end else if (abort_now) begin
        active_q <= 1'b0;
        cause_q  <= cause_d;
        status_q <= cause_d;
      end else if (commit_now) begin
        active_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (commit_now) begin
      for (int i = 0; i < ENTRIES; i++) begin
        wb_line_q[i] <= line_a[i];
        wb_data_q[i] <= data_a[i];
      end
    end
  end

  assign active_o       = active_q;
  assign abort_o        = abort_q;
  assign abort_cause_o  = cause_q;
  assign start_status_o = status_q;
  assign restart_pc_o   = pc_q;
  assign illegal_o      = illegal_q;
  assign wb_mask_o      = wb_mask_q;

  // no line is held twice
  assert_unique_line_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_v));

  assert_abort_cause_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> (cause_q != CAUSE_NONE && !active_q));

  assert_abort_no_wb_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> (wb_mask_q == '0));

  assert_cause_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!abort_q && !(active_q && !$past(active_q))) |-> $stable(cause_q));

  assert_status_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_q |-> (status_q == cause_q));

  assert_capacity_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_q && cause_q == CAUSE_CAP) |-> $past(&valid_v));

  assert_wb_after_commit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_mask_q != '0) |-> ($past(active_q) && !active_q));

endmodule

// File: tb/spec_line_tracker_tb_top.sv
`timescale 1ns/1ps
module spec_line_tracker_tb_top;

  localparam int ADDR_W = 32, OFF_W = 6, DATA_W = 32, N = 8;
  localparam int LW = ADDR_W - OFF_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 0, snp_valid = 0;
  logic [3:0]        req_op = 0;
  logic [ADDR_W-1:0] req_addr = 0, snp_addr = 0;
  logic [DATA_W-1:0] req_data = 0;
  logic [1:0]        snp_kind = 0;

  logic              active, abort_p, illegal;
  logic [1:0]        cause, status;
  logic [DATA_W-1:0] pc;
  logic [N-1:0]      wb_mask;
  logic [N*LW-1:0]   wb_line;
  logic [N*DATA_W-1:0] wb_data;

  spec_line_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_addr_i(req_addr), .req_data_i(req_data),
    .snoop_valid_i(snp_valid), .snoop_kind_i(snp_kind), .snoop_addr_i(snp_addr),
    .active_o(active), .abort_o(abort_p), .abort_cause_o(cause), .start_status_o(status),
    .restart_pc_o(pc), .illegal_o(illegal),
    .wb_mask_o(wb_mask), .wb_line_o(wb_line), .wb_data_o(wb_data)
  );

  // request codes and snoop kinds as listed in R5 and R3
  localparam logic [3:0] BEG = 0, PLD = 1, PST = 2, WS = 3, WX = 4, REL = 5, ABT = 6,
                         CMT = 7, NSL = 8, NSS = 9;
  localparam logic [1:0] S_RD = 0, S_PF = 1, S_WR = 2, S_PX = 3;

  int    n_chk = 0, n_err = 0;
  bit    done = 0;
  string cur = "reset";

  // reference model
  bit              m_active = 0, m_abort = 0, m_ill = 0;
  logic [1:0]      m_cause = 0, m_status = 0;
  logic [DATA_W-1:0] m_pc = 0;
  logic [LW-1:0]   q_line[$];
  bit              q_own[$], q_has[$];
  logic [DATA_W-1:0] q_data[$];
  logic [LW-1:0]   e_line[$];
  logic [DATA_W-1:0] e_data[$];

  task automatic m_clear();
    q_line.delete(); q_own.delete(); q_has.delete(); q_data.delete();
  endtask

  task automatic m_abort_with(logic [1:0] c);
    m_active = 0; m_cause = c; m_status = c; m_abort = 1; m_clear();
  endtask

  function automatic int m_find(logic [LW-1:0] l);
    int idx = -1;
    foreach (q_line[k]) if (q_line[k] == l) idx = k;
    return idx;
  endfunction

  task automatic model();
    logic [LW-1:0] rl = req_addr[ADDR_W-1:OFF_W];
    logic [LW-1:0] sl = snp_addr[ADDR_W-1:OFF_W];
    bit cfl = 0;
    int h;
    m_abort = 0; m_ill = 0;
    e_line.delete(); e_data.delete();
    if (m_active) begin
      if (snp_valid) begin
        h = m_find(sl);
        if (h >= 0 && (snp_kind[1] || q_own[h])) cfl = 1;
      end
      if (cfl) m_abort_with(2'b01);
      else if (req_valid) begin
        h = m_find(rl);
        case (req_op)
          PLD, PST, WS, WX: begin
            if (h < 0 && q_line.size() == N) m_abort_with(2'b10);
            else begin
              if (h < 0) begin
                q_line.push_back(rl); q_own.push_back(0); q_has.push_back(0); q_data.push_back(0);
                h = q_line.size() - 1;
              end
              if (req_op == PST || req_op == WX) q_own[h] = 1;
              if (req_op == PST) begin q_has[h] = 1; q_data[h] = req_data; end
            end
          end
          REL: if (h >= 0 && !q_has[h]) begin
            q_line.delete(h); q_own.delete(h); q_has.delete(h); q_data.delete(h);
          end
          ABT: m_abort_with(2'b11);
          CMT: begin
            foreach (q_line[k]) if (q_has[k]) begin e_line.push_back(q_line[k]); e_data.push_back(q_data[k]); end
            m_clear(); m_active = 0;
          end
          NSS: if (h >= 0) m_ill = 1;
          default: ;
        endcase
      end
    end else if (req_valid && req_op == BEG) begin
      m_active = 1; m_cause = 0; m_status = 0; m_pc = req_data; m_clear();
    end
  endtask

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", cur, what, act, exp);
    end
  endtask

  task automatic compare();
    int cnt = 0;
    chk("active", active, m_active);
    chk("abort", abort_p, m_abort);
    chk("cause", cause, m_cause);
    chk("status", status, m_status);
    chk("restart", pc, m_pc);
    chk("illegal", illegal, m_ill);
    foreach (wb_mask[i]) cnt += wb_mask[i];
    chk("wb_count", cnt, e_line.size());
    foreach (e_line[k]) begin
      bit f = 0;
      for (int i = 0; i < N; i++)
        if (wb_mask[i] && wb_line[i*LW +: LW] == e_line[k] && wb_data[i*DATA_W +: DATA_W] == e_data[k]) f = 1;
      chk("wb_entry", f, 1);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model();
    @(negedge clk);
    compare();
    req_valid = 0; snp_valid = 0;
  endtask

  task automatic rq(logic [3:0] op, logic [31:0] a, logic [31:0] d = 0);
    req_valid = 1; req_op = op; req_addr = a; req_data = d;
    step();
  endtask

  task automatic sn(logic [1:0] k, logic [31:0] a);
    snp_valid = 1; snp_kind = k; snp_addr = a;
    step();
  endtask

  task automatic both(logic [3:0] op, logic [31:0] a, logic [1:0] k, logic [31:0] sa);
    req_valid = 1; req_op = op; req_addr = a; req_data = 0;
    snp_valid = 1; snp_kind = k; snp_addr = sa;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    cur = "R12 reset";
    idle(3);
    @(negedge clk); rst_n = 1;
    idle(1);

    cur = "R8 begin";
    rq(BEG, 0, 32'h400);
    cur = "R3 shared";
    rq(PLD, 32'h1000);
    sn(S_RD, 32'h1000);
    sn(S_PF, 32'h1010);
    cur = "R1 same line other offset";
    sn(S_WR, 32'h1020);
    cur = "R12 hold";
    idle(2);
    sn(S_WR, 32'h1000);

    cur = "R3 owned read";
    rq(BEG, 0, 32'h500);
    rq(PST, 32'h2000, 32'hAA);
    sn(S_RD, 32'h2008);
    cur = "R11 commit inactive";
    rq(CMT, 0);
    rq(PLD, 32'h2000);

    cur = "R5 upgrade";
    rq(BEG, 0, 32'h600);
    rq(WS, 32'h3000);
    sn(S_PF, 32'h3000);
    rq(WX, 32'h3000);
    rq(PLD, 32'h3000);
    sn(S_RD, 32'h3000);

    cur = "R6 release";
    rq(BEG, 0, 32'h700);
    rq(PLD, 32'h4000);
    rq(REL, 32'h4000);
    sn(S_WR, 32'h4000);
    rq(PST, 32'h5000, 32'h55);
    rq(REL, 32'h5000);
    cur = "R4 exclusive prefetch";
    sn(S_PX, 32'h5004);

    cur = "R9 same-cycle snoop";
    rq(BEG, 0, 32'h800);
    both(PLD, 32'h6000, S_WR, 32'h6000);
    sn(S_WR, 32'h6000);

    cur = "R10 illegal store";
    rq(BEG, 0, 32'h900);
    rq(PLD, 32'h7000);
    rq(NSS, 32'h7010);
    rq(NSS, 32'h8000);
    rq(NSL, 32'h7000);
    cur = "R4 write on shared";
    sn(S_WR, 32'h7000);

    cur = "R2 capacity";
    rq(BEG, 0, 32'hA00);
    for (int i = 0; i < N; i++) rq(PLD, 32'h10000 + i * 64);
    rq(PST, 32'h10000 + 3 * 64, 32'h33);
    rq(PLD, 32'h20000);

    cur = "R7 explicit abort";
    rq(BEG, 0, 32'hB00);
    rq(PST, 32'h9000, 32'h77);
    rq(ABT, 0);
    rq(CMT, 0);

    cur = "R4 priority over local abort";
    rq(BEG, 0, 32'hB40);
    rq(PLD, 32'hC000);
    both(ABT, 0, S_WR, 32'hC000);

    cur = "R11 commit";
    rq(BEG, 0, 32'hC00);
    rq(PST, 32'h9000, 32'hD1);
    rq(PST, 32'h9040, 32'hD2);
    rq(PLD, 32'hA000);
    rq(PST, 32'h9004, 32'hD3);
    cur = "R8 begin while active";
    rq(BEG, 0, 32'hFFF);
    cur = "R11 commit";
    rq(CMT, 0);
    idle(1);
    cur = "R12 snoop inactive";
    sn(S_WR, 32'h9000);
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule